// File: doc/BRIEF.md
# Serial Configuration Register Slave

This block is a three-wire serial slave that gives a host read and write access to a bank of sixteen 8-bit configuration registers. The host raises an enable line and toggles a serial clock. Bits on the data input are taken on clock rising edges. Each frame starts with an 8-bit address word, sent least significant bit first. In the address word, bit 0 gives the direction, bits 1 and 2 select the device, and bits 3 to 6 give the register index. Bit 7 is not used. A data word follows the address word. For a write, the slave keeps the last eight bits it received and copies them into the addressed register when the enable line falls. For a read, the slave loads the addressed register as soon as the address is decoded and shifts it out, least significant bit first.

Two strap inputs give each slave its device identity. A broadcast input, active low, lets the host reach every slave on a shared bus at the same time. All bus lines are sampled in a single system-clock domain through synchronizers, and edges are detected on the synchronized copies. The register contents are also brought out in parallel to drive the rest of the chip. The serial output comes with an enable, so the pad can be tri-stated.

Top module: `cfgSerialSlave`

## Requirements
- R1: Address bits arrive least significant first as a0..a7. The register index is a3..a6 (a3 is the index LSB), and a7 has no effect on which register is used.
- R2: Address bit a0 sets the direction: 0 writes and 1 reads.
- R3: When `bcastN` is 1, a frame is accepted only if a1 equals `strap0` and a2 equals `strap1`. Any other frame changes no register and never enables the output.
- R4: When `bcastN` is 0, a frame is accepted only if a1 and a2 are both 1, whatever the straps are.
- R5: On an accepted write of 16 or more bits, the falling edge of `serEn` copies the last eight received bits into the addressed register. The earliest of those eight bits goes to register bit 0.
- R6: A write frame that ends before 16 bits have been clocked in changes no register.
- R7: On an accepted read, register bit 0 is on `serDout` before the first data-phase rising edge of `serClk`. Each later bit replaces it after the falling edge that follows each data-phase rising edge.
- R8: If `serEn` falls during the read data phase, `serDoe` goes low within a few system clocks and stays low.
- R9: `serDoe` is 1 only during the eight-bit data phase of an accepted read. It is 0 during the address phase, after the eighth data bit has been shifted out (following the falling edge after the 16th rising edge), and between frames.
- R10: After reset, every register reads zero and `serDoe` is 0. The bit counter restarts every time `serEn` is low, so a frame cut short inside the address phase has no effect on the next frame.
- R11: `cfgRegs[8*i+7:8*i]` always holds register i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| strap0 | input | 1 | Device identity strap compared with a1 |
| strap1 | input | 1 | Device identity strap compared with a2 |
| bcastN | input | 1 | Broadcast select, active low |
| serEn | input | 1 | Frame enable from host, high during a frame |
| serClk | input | 1 | Serial clock from host |
| serDin | input | 1 | Serial data from host |
| serDout | output | 1 | Serial read data to host |
| serDoe | output | 1 | Output enable for the serial data pad |
| cfgRegs | output | 128 | All registers in parallel, register i at bits 8*i+7..8*i |

## Verification
The bench uses the default parameters: sixteen 8-bit registers, the index at address bits 3 to 6, and two synchronizer stages. With these values, random frames can reach every register index, both polarities of every direction and selection bit, and both the strap-match and broadcast paths. Frame lengths run from a few bits to 24 bits, so the bench covers aborted address phases, short writes, writes longer than 16 bits where only the last eight bits count, and reads cut off partway through the data phase.

// File: rtl/serslv_pkg.sv
package serslv_pkg;
  typedef struct packed {
    logic shiftAddr;
    logic shiftData;
    logic loadRead;
    logic shiftOut;
    logic commit;
  } strobe_t;
endpackage

// File: rtl/serSync.sv
module serSync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] pipe [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : gStage
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) pipe[s] <= '0;
        else if (s == 0) pipe[s] <= asyncIn;
        else pipe[s] <= pipe[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign syncOut = pipe[STAGES-1];
endmodule

// File: rtl/serCtrl.sv
module serCtrl
  import serslv_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enS,
  input  logic              sclkS,
  input  logic              dinS,
  input  logic              strap0,
  input  logic              strap1,
  input  logic              bcastN,
  input  logic [ADDR_W-1:0] addrWord,
  output strobe_t           stb,
  output logic              outEn,
  output logic [CNT_W-1:0]  bitCnt
);
  localparam int FRAME_BITS = ADDR_W + DATA_W;
  localparam logic [CNT_W-1:0] CNT_MAX   = CNT_W'(FRAME_BITS + 1);
  localparam logic [CNT_W-1:0] CNT_LASTA = CNT_W'(ADDR_W - 1);
  localparam logic [CNT_W-1:0] CNT_ADDR  = CNT_W'(ADDR_W);
  localparam logic [CNT_W-1:0] CNT_FRAME = CNT_W'(FRAME_BITS);

  logic sclkPrev, enPrev;
  logic rise, fall, enFall;
  logic [ADDR_W-1:0] newAddr;
  logic lastAddrBit, selected;
  logic wrSel, rdActive;

  assign rise   = sclkS & ~sclkPrev;
  assign fall   = ~sclkS & sclkPrev;
  assign enFall = enPrev & ~enS;

  // address word as it will look once the current bit is shifted in
  assign newAddr     = {dinS, addrWord[ADDR_W-1:1]};
  assign lastAddrBit = rise && enS && (bitCnt == CNT_LASTA);
  assign selected    = bcastN ? ((newAddr[1] == strap0) && (newAddr[2] == strap1))
                              : (newAddr[1] && newAddr[2]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkPrev <= 1'b0;
      enPrev   <= 1'b0;
    end else begin
      sclkPrev <= sclkS;
      enPrev   <= enS;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) bitCnt <= '0;
    else if (!enS) bitCnt <= '0;
    else if (rise && (bitCnt != CNT_MAX)) bitCnt <= bitCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrSel    <= 1'b0;
      rdActive <= 1'b0;
    end else if (!enS) begin
      wrSel    <= 1'b0;
      rdActive <= 1'b0;
    end else if (lastAddrBit) begin
      wrSel    <= selected & ~newAddr[0];
      rdActive <= selected & newAddr[0];
    end else if (fall && rdActive && (bitCnt >= CNT_FRAME)) begin
      rdActive <= 1'b0;
    end
  end

  always_comb begin
    stb.shiftAddr = rise && enS && (bitCnt < CNT_ADDR);
    stb.shiftData = rise && enS && (bitCnt >= CNT_ADDR);
    stb.loadRead  = lastAddrBit && selected && newAddr[0];
    stb.shiftOut  = fall && enS && rdActive && (bitCnt > CNT_ADDR) && (bitCnt < CNT_FRAME);
    stb.commit    = enFall && wrSel && (bitCnt >= CNT_FRAME);
  end

  assign outEn = rdActive;
endmodule

// File: rtl/serDatapath.sv
module serDatapath
  import serslv_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int ADDR_W  = 8,
  parameter int REG_NUM = 16,
  parameter int IDX_LSB = 3
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  strobe_t                   stb,
  input  logic                      dinS,
  output logic [ADDR_W-1:0]         addrWord,
  output logic [REG_NUM*DATA_W-1:0] cfgFlat,
  output logic                      dout
);
  localparam int IDX_W = $clog2(REG_NUM);

  logic [DATA_W-1:0] regs [REG_NUM];
  logic [DATA_W-1:0] dataSh, outSh;
  logic [ADDR_W-1:0] newAddr;
  logic [IDX_W-1:0]  rdIdx, wrIdx;

  assign newAddr = {dinS, addrWord[ADDR_W-1:1]};
  assign rdIdx   = newAddr[IDX_LSB +: IDX_W];
  assign wrIdx   = addrWord[IDX_LSB +: IDX_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrWord <= '0;
      dataSh   <= '0;
      outSh    <= '0;
    end else begin
      if (stb.shiftAddr) addrWord <= newAddr;
      if (stb.shiftData) dataSh <= {dinS, dataSh[DATA_W-1:1]};
      if (stb.loadRead) outSh <= regs[rdIdx];
      else if (stb.shiftOut) outSh <= {1'b0, outSh[DATA_W-1:1]};
    end
  end

  genvar i;
  generate
    for (i = 0; i < REG_NUM; i++) begin : gReg
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) regs[i] <= '0;
        else if (stb.commit && (wrIdx == IDX_W'(i))) regs[i] <= dataSh;
      end
      assign cfgFlat[i*DATA_W +: DATA_W] = regs[i];
    end
  endgenerate

  assign dout = outSh[0];
endmodule

// File: rtl/cfgSerialSlave.sv
module cfgSerialSlave
  import serslv_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 8,
  parameter int REG_NUM     = 16,
  parameter int IDX_LSB     = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      strap0,
  input  logic                      strap1,
  input  logic                      bcastN,
  input  logic                      serEn,
  input  logic                      serClk,
  input  logic                      serDin,
  output logic                      serDout,
  output logic                      serDoe,
  output logic [REG_NUM*DATA_W-1:0] cfgRegs
);
  localparam int CNT_W = $clog2(ADDR_W + DATA_W + 2);

  logic [2:0]        syncOut;
  logic              enS, sclkS, dinS;
  strobe_t           stb;
  logic [ADDR_W-1:0] addrWord;
  logic [CNT_W-1:0]  bitCnt;

  serSync #(.WIDTH(3), .STAGES(SYNC_STAGES)) uSync (
    .clk(clk), .rstN(rstN), .asyncIn({serEn, serClk, serDin}), .syncOut(syncOut)
  );
  assign {enS, sclkS, dinS} = syncOut;

  serCtrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) uCtrl (
    .clk(clk), .rstN(rstN), .enS(enS), .sclkS(sclkS), .dinS(dinS),
    .strap0(strap0), .strap1(strap1), .bcastN(bcastN), .addrWord(addrWord),
    .stb(stb), .outEn(serDoe), .bitCnt(bitCnt)
  );

  serDatapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .REG_NUM(REG_NUM), .IDX_LSB(IDX_LSB)) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .dinS(dinS),
    .addrWord(addrWord), .cfgFlat(cfgRegs), .dout(serDout)
  );
endmodule

// File: rtl/serCheck.sv
module serCheck
  import serslv_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int REG_NUM = 16,
  parameter int CNT_W   = 5
) (
  input logic                      clk,
  input logic                      rstN,
  input logic                      enS,
  input strobe_t                   stb,
  input logic [CNT_W-1:0]          bitCnt,
  input logic                      serDout,
  input logic                      serDoe,
  input logic [REG_NUM*DATA_W-1:0] cfgRegs
);
  AST_DOE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rstN) serDoe |-> $past(enS)); // R9
  AST_DOE_DROPS: assert property (@(posedge clk) disable iff (!rstN) !enS |=> !serDoe); // R8
  AST_REGS_HOLD: assert property (@(posedge clk) disable iff (!rstN) !stb.commit |=> $stable(cfgRegs)); // R6
  AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rstN) !enS |=> (bitCnt == '0)); // R10
  AST_DOUT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (serDoe && !stb.shiftOut && !stb.loadRead) |=> $stable(serDout)); // R7
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.shiftAddr, stb.shiftData, stb.commit})); // R1
endmodule

bind cfgSerialSlave serCheck #(.DATA_W(DATA_W), .REG_NUM(REG_NUM), .CNT_W(CNT_W)) uChk (
  .clk(clk), .rstN(rstN), .enS(enS), .stb(stb), .bitCnt(bitCnt),
  .serDout(serDout), .serDoe(serDoe), .cfgRegs(cfgRegs)
);

// File: tb/sim_cfgSerialSlave.sv
module sim_cfgSerialSlave;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 6;
  localparam int NREG = 16;
  localparam logic S0 = 1'b1;
  localparam logic S1 = 1'b0;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bcastN = 1'b1;
  logic serEn = 1'b0, serClk = 1'b0, serDin = 1'b0;
  logic serDout, serDoe;
  logic [NREG*8-1:0] cfgRegs;

  int compared = 0;
  int mismatched = 0;
  int cyc = 0;
  bit finished = 0;
  logic [7:0] mdl [NREG];

  always #(CLK_PERIOD/2) clk = ~clk;

  cfgSerialSlave u0 (
    .clk(clk), .rstN(rstN), .strap0(S0), .strap1(S1), .bcastN(bcastN),
    .serEn(serEn), .serClk(serClk), .serDin(serDin),
    .serDout(serDout), .serDoe(serDoe), .cfgRegs(cfgRegs)
  );

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] mkAddr(input int idx, input bit a1, input bit a2, input bit rd, input bit a7);
    return {a7, 4'(idx), a2, a1, rd};
  endfunction

  function automatic bit accepted(input logic [7:0] a, input logic bc);
    return bc ? (a[1] == S0 && a[2] == S1) : (a[1] && a[2]);
  endfunction

  function automatic logic [127:0] mdlFlat();
    logic [127:0] f = '0;
    for (int i = 0; i < NREG; i++) f[i*8 +: 8] = mdl[i];
    return f;
  endfunction

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one frame of nBits bits; records read data and output-enable observations
  task automatic runFrame(input logic [7:0] addr, input logic [15:0] wdata, input int nBits,
                          output logic [7:0] got, output int oeData, output int oeStray);
    got = '0; oeData = 0; oeStray = 0;
    serEn = 1'b1;
    waitClk(HALF);
    for (int i = 0; i < nBits; i++) begin
      serClk = 1'b0;
      serDin = (i < 8) ? addr[i] : wdata[i-8];
      waitClk(HALF);
      if (i >= 8 && i < 16) begin
        got[i-8] = serDout;
        if (serDoe) oeData++;
      end else if (serDoe) oeStray++;
      serClk = 1'b1;
      waitClk(HALF);
    end
    serClk = 1'b0;
    waitClk(HALF);
    if (nBits >= 16 && serDoe) oeStray++;
    serEn = 1'b0;
    waitClk(6);
    if (serDoe) oeStray++;
    waitClk(HALF);
  endtask

  task automatic doFrame(input logic [7:0] addr, input logic [15:0] wdata, input int nBits, input string tag);
    logic [7:0] got, expRd;
    int oeData, oeStray, nRd, expOe;
    bit acc;
    acc = accepted(addr, bcastN);
    expRd = mdl[addr[6:3]];
    runFrame(addr, wdata, nBits, got, oeData, oeStray);
    nRd = (nBits > 16) ? 8 : ((nBits > 8) ? nBits - 8 : 0);
    if (acc && !addr[0] && nBits >= 16) mdl[addr[6:3]] = wdata[(nBits-16) +: 8];
    expOe = (acc && addr[0]) ? nRd : 0;
    check(cfgRegs === mdlFlat(), {tag, " R5 R6 R11 regs"}, cfgRegs, mdlFlat());
    check(oeStray == 0, {tag, " R8 R9 stray drive"}, oeStray, 0);
    if (addr[0]) begin
      check(oeData == expOe, {tag, " R3 R4 R9 read enable"}, oeData, expOe);
      if (expOe > 0) begin
        logic [7:0] mask;
        mask = 8'((9'h1 << nRd) - 1);
        check((got & mask) === (expRd & mask), {tag, " R2 R7 read data"}, got & mask, expRd & mask);
      end
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000 && !finished) begin
      finished = 1;
      mismatched++;
      compared++;
      $display("FAIL watchdog actual=%0d expected<190000", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NREG; i++) mdl[i] = 8'h00;
    waitClk(4);
    rstN = 1'b1;
    waitClk(4);
    // R10 reset state
    check(cfgRegs === '0, "R10 reset regs", cfgRegs, 0);
    check(serDoe === 1'b0, "R10 reset oe", serDoe, 0);

    bcastN = 1'b1;
    doFrame(mkAddr(5, S0, S1, 0, 1), 16'h00A5, 16, "R1 R3 strap write");
    doFrame(mkAddr(5, S0, S1, 1, 0), 16'h0000, 16, "R1 R2 read back a7=0");
    doFrame(mkAddr(5, S0, S1, 1, 1), 16'h0000, 16, "R1 read back a7=1");
    doFrame(mkAddr(5, !S0, S1, 0, 0), 16'h00FF, 16, "R3 strap mismatch write");
    doFrame(mkAddr(5, S0, !S1, 1, 0), 16'h0000, 16, "R3 strap mismatch read");
    bcastN = 1'b0;
    doFrame(mkAddr(9, 1, 1, 0, 0), 16'h003C, 16, "R4 broadcast write");
    doFrame(mkAddr(9, S0, S1, 0, 0), 16'h00C3, 16, "R4 broadcast needs ones");
    doFrame(mkAddr(9, 1, 1, 1, 0), 16'h0000, 16, "R4 broadcast read");
    bcastN = 1'b1;
    doFrame(mkAddr(2, S0, S1, 0, 0), 16'hB74D, 20, "R5 last eight of twenty");
    doFrame(mkAddr(2, S0, S1, 0, 0), 16'h0FFF, 12, "R6 short write");
    doFrame(mkAddr(2, S0, S1, 1, 0), 16'h0000, 5, "R10 aborted address");
    doFrame(mkAddr(2, S0, S1, 1, 0), 16'h0000, 11, "R8 interrupted read");
    doFrame(mkAddr(15, S0, S1, 0, 0), 16'h0081, 16, "R10 frame after abort");
    doFrame(mkAddr(15, S0, S1, 1, 0), 16'h0000, 16, "R7 read top index");

    for (int n = 0; n < 250; n++) begin
      logic [7:0] a;
      int len;
      a = 8'($urandom);
      if ($urandom % 4 != 0) begin
        a[1] = ($urandom % 2 == 0) ? S0 : 1'b1;
        a[2] = ($urandom % 2 == 0) ? S1 : 1'b1;
      end
      bcastN = ($urandom % 3 != 0);
      len = ($urandom % 3 == 0) ? int'($urandom % 25) : 16;
      doFrame(a, 16'($urandom), len, "R1 R5 random");
    end

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule